// File: doc/BRIEF.md
# Integer ALU with shifter

A purely combinational 32-bit execution unit for the integer side of a load/store RISC pipeline. Each cycle the issuing stage presents a 5-bit operation code, two register operands and a 5-bit constant shift field. The unit returns one 32-bit result and a flag that asks the core to raise an arithmetic-overflow trap. The unit only raises the request. Taking the trap, and any multiply, divide or memory work, belongs to other blocks.

The operations are:
- add and subtract, each in a trapping and a wrapping form;
- signed and unsigned compare-and-set;
- the four bitwise operations AND, OR, XOR and NOR;
- placing an immediate in the upper half of the word;
- shifts left, logical right and arithmetic right, each in two forms.

Every shift moves operand B. The shift count comes either from the constant field or from the low five bits of operand A.

Top module: `int_exec_alu`

## Requirements
- R1: Codes 1 (add) and 3 (subtract, A minus B) return the sum or difference modulo 2^32 and never assert the overflow flag.
- R2: Codes 0 (add) and 2 (subtract) return the same bit pattern as codes 1 and 3. They assert the overflow flag exactly when the true signed result lies outside the 32-bit two's-complement range.
- R3: The overflow flag is low for every code other than 0 and 2.
- R4: Code 4 returns 1 when A is less than B as two's-complement numbers and 0 otherwise, in bit 0, with bits 31..1 zero.
- R5: Code 5 returns 1 when A is less than B as unsigned magnitudes and 0 otherwise, in bit 0, with bits 31..1 zero.
- R6: Codes 6, 7, 8 and 9 return A AND B, A OR B, A XOR B and NOR(A, B) respectively. NOR of 0xFF00FF00 and 0xF0F0F0F0 gives 0x000F000F.
- R7: Code 10 returns B bits 15..0 in result bits 31..16, with result bits 15..0 zero.
- R8: Codes 11, 12 and 13 shift B by the constant field. Code 11 shifts left and code 12 shifts right, both filling with zeros. Code 13 shifts right and fills with B bit 31.
- R9: Codes 14, 15 and 16 perform the shifts of codes 11, 12 and 13 with the count taken from A bits 4..0. A bits 31..5 have no effect on the result.
- R10: Codes 17 to 31 return zero and keep the overflow flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code |
| src_a | input | 32 | First operand; count source for register-count shifts |
| src_b | input | 32 | Second operand; value moved by shifts and upper-immediate |
| shamt_imm | input | 5 | Constant shift count |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Request for an arithmetic-overflow trap |

## Verification
The adder is driven with pairs chosen to separate the cases:
- The largest positive and most negative values, and -1 against 1, tell signed overflow apart from a plain carry out.
- The same pairs decide whether the signed and unsigned compares disagree, as they must when the operand signs differ.

Shifts are tried with counts 0, 1 and 31, and with negative B, which separates arithmetic fill from logical fill. Register-count shifts use an A whose upper bits are set, so that any use of bits above bit 4 would change the result. Random codes, including the unused ones, with mostly random and sometimes corner operands then cover the rest against a reference model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD_TRAP = 5'd0,
        OP_ADD_WRAP = 5'd1,
        OP_SUB_TRAP = 5'd2,
        OP_SUB_WRAP = 5'd3,
        OP_LT_SGN   = 5'd4,
        OP_LT_UNS   = 5'd5,
        OP_AND      = 5'd6,
        OP_OR       = 5'd7,
        OP_XOR      = 5'd8,
        OP_NOR      = 5'd9,
        OP_UPPER    = 5'd10,
        OP_SHL_K    = 5'd11,
        OP_SHR_K    = 5'd12,
        OP_SHA_K    = 5'd13,
        OP_SHL_R    = 5'd14,
        OP_SHR_R    = 5'd15,
        OP_SHA_R    = 5'd16
    } alu_op_e;

    typedef enum logic [2:0] {
        U_NONE, U_ARITH, U_CMP, U_BITS, U_UPPER, U_SHIFT
    } alu_unit_e;

    typedef enum logic [1:0] {
        BF_AND = 2'd0, BF_OR = 2'd1, BF_XOR = 2'd2, BF_NOR = 2'd3
    } bits_fn_e;

    typedef struct packed {
        alu_unit_e unit;
        logic      sub;
        logic      trap;
        logic      uns;
        bits_fn_e  bfn;
        logic      left;
        logic      arith;
        logic      cnt_reg;
    } alu_ctl_t;

    function automatic alu_ctl_t alu_decode(input logic [4:0] code);
        alu_ctl_t c;
        c = '{unit: U_NONE, sub: 1'b0, trap: 1'b0, uns: 1'b0,
              bfn: BF_AND, left: 1'b0, arith: 1'b0, cnt_reg: 1'b0};
        case (code)
            OP_ADD_TRAP: begin c.unit = U_ARITH; c.trap = 1'b1; end
            OP_ADD_WRAP: c.unit = U_ARITH;
            OP_SUB_TRAP: begin c.unit = U_ARITH; c.sub = 1'b1; c.trap = 1'b1; end
            OP_SUB_WRAP: begin c.unit = U_ARITH; c.sub = 1'b1; end
            OP_LT_SGN:   begin c.unit = U_CMP; c.sub = 1'b1; end
            OP_LT_UNS:   begin c.unit = U_CMP; c.sub = 1'b1; c.uns = 1'b1; end
            OP_AND:      begin c.unit = U_BITS; c.bfn = BF_AND; end
            OP_OR:       begin c.unit = U_BITS; c.bfn = BF_OR; end
            OP_XOR:      begin c.unit = U_BITS; c.bfn = BF_XOR; end
            OP_NOR:      begin c.unit = U_BITS; c.bfn = BF_NOR; end
            OP_UPPER:    c.unit = U_UPPER;
            OP_SHL_K:    begin c.unit = U_SHIFT; c.left = 1'b1; end
            OP_SHR_K:    c.unit = U_SHIFT;
            OP_SHA_K:    begin c.unit = U_SHIFT; c.arith = 1'b1; end
            OP_SHL_R:    begin c.unit = U_SHIFT; c.left = 1'b1; c.cnt_reg = 1'b1; end
            OP_SHR_R:    begin c.unit = U_SHIFT; c.cnt_reg = 1'b1; end
            OP_SHA_R:    begin c.unit = U_SHIFT; c.arith = 1'b1; c.cnt_reg = 1'b1; end
            default:     c.unit = U_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf_raw,
    output logic         lt_sgn,
    output logic         lt_uns
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff   = sub ? ~b : b;
        wide    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum     = wide[W-1:0];
        // same-sign inputs to the adder producing a result of the other sign
        ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        // valid while subtracting: no carry out means a borrow
        lt_uns  = ~wide[W];
        lt_sgn  = (a[MSB] != b[MSB]) ? a[MSB] : sum[MSB];
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  bits_fn_e     fn,
    output logic [W-1:0] y
);
    always_comb begin
        case (fn)
            BF_AND:  y = a & b;
            BF_OR:   y = a | b;
            BF_XOR:  y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/alu_barrel.sv
module alu_barrel #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] cnt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  dout
);
    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stage [SW+1];
    logic         fill;

    // left shifts run through the right-shift stages on a bit-reversed word
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]  = din[W-1-i];
        assign rev_out[i] = stage[SW][W-1-i];
    end

    assign fill     = arith & ~left & din[W-1];
    assign stage[0] = left ? rev_in : din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = cnt[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
    end

    assign dout = left ? rev_out : stage[SW];
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import alu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [4:0]      op_sel,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [SHW-1:0]  shamt_imm,
    output logic [XLEN-1:0] result,
    output logic            ovf_trap
);
    localparam int IMMW = XLEN / 2;

    alu_ctl_t        ctl;
    logic [XLEN-1:0] sum_q, bits_q, shift_q, upper_q;
    logic            ovf_raw, lt_sgn, lt_uns;
    logic [SHW-1:0]  cnt;

    assign ctl     = alu_decode(op_sel);
    assign cnt     = ctl.cnt_reg ? src_a[SHW-1:0] : shamt_imm;
    assign upper_q = {src_b[IMMW-1:0], {IMMW{1'b0}}};

    alu_addsub #(.W(XLEN)) u_addsub (
        .a(src_a), .b(src_b), .sub(ctl.sub),
        .sum(sum_q), .ovf_raw(ovf_raw), .lt_sgn(lt_sgn), .lt_uns(lt_uns)
    );

    alu_bitwise #(.W(XLEN)) u_bits (
        .a(src_a), .b(src_b), .fn(ctl.bfn), .y(bits_q)
    );

    alu_barrel #(.W(XLEN), .SW(SHW)) u_shift (
        .din(src_b), .cnt(cnt), .left(ctl.left), .arith(ctl.arith), .dout(shift_q)
    );

    always_comb begin
        case (ctl.unit)
            U_ARITH: result = sum_q;
            U_CMP:   result = {{(XLEN-1){1'b0}}, ctl.uns ? lt_uns : lt_sgn};
            U_BITS:  result = bits_q;
            U_UPPER: result = upper_q;
            U_SHIFT: result = shift_q;
            default: result = '0;
        endcase
        ovf_trap = ctl.trap & ovf_raw;
    end
endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input logic [4:0]      op_sel,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [SHW-1:0]  shamt_imm,
    input logic [XLEN-1:0] result,
    input logic            ovf_trap
);
    localparam int IMMW = XLEN / 2;
    localparam int MSB  = XLEN - 1;

    always_comb begin
        if (ovf_trap) begin
            p_trap_codes_r3: assert (op_sel == 5'd0 || op_sel == 5'd2);
        end
        if (ovf_trap && op_sel == 5'd0) begin
            p_add_sign_rule_r2: assert (src_a[MSB] == src_b[MSB] && result[MSB] != src_a[MSB]);
        end
        if (ovf_trap && op_sel == 5'd2) begin
            p_sub_sign_rule_r2: assert (src_a[MSB] != src_b[MSB] && result[MSB] != src_a[MSB]);
        end
        if (op_sel == 5'd4) begin
            p_lt_sgn_ext_r4: assert (result[MSB:1] == '0);
        end
        if (op_sel == 5'd5) begin
            p_lt_uns_ext_r5: assert (result[MSB:1] == '0);
        end
        if (op_sel == 5'd10) begin
            p_upper_place_r7: assert (result[IMMW-1:0] == '0 && result[MSB:IMMW] == src_b[IMMW-1:0]);
        end
        if (op_sel == 5'd13) begin
            p_sha_keep_sign_r8: assert (result[MSB] == src_b[MSB]);
        end
        if (op_sel > 5'd16) begin
            p_unused_quiet_r10: assert (result == '0 && !ovf_trap);
        end
    end
endmodule

bind int_exec_alu alu_chk #(.XLEN(XLEN), .SHW(SHW)) u_chk (
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .shamt_imm(shamt_imm),
    .result(result), .ovf_trap(ovf_trap)
);

// File: tb/sim_int_exec_alu.sv
module sim_int_exec_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [4:0]  shamt_imm = '0;
    logic [31:0] result;
    logic        ovf_trap;
    int          total = 0, bad = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_exec_alu u0 (
        .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .shamt_imm(shamt_imm),
        .result(result), .ovf_trap(ovf_trap)
    );

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd2:             return "R2";
            5'd1, 5'd3:             return "R1";
            5'd4:                   return "R4";
            5'd5:                   return "R5";
            5'd6, 5'd7, 5'd8, 5'd9: return "R6";
            5'd10:                  return "R7";
            5'd11, 5'd12, 5'd13:    return "R8";
            5'd14, 5'd15, 5'd16:    return "R9";
            default:                return "R10";
        endcase
    endfunction

    function automatic void model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                                  input logic [4:0] sh, output logic [31:0] r, output logic ov);
        longint sa, sb, exact;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ov = 1'b0;
        r  = '0;
        case (op)
            5'd0, 5'd1: begin exact = sa + sb; r = a + b; ov = (op == 5'd0) && (exact != longint'($signed(r))); end
            5'd2, 5'd3: begin exact = sa - sb; r = a - b; ov = (op == 5'd2) && (exact != longint'($signed(r))); end
            5'd4:  r = (sa < sb) ? 32'd1 : 32'd0;
            5'd5:  r = (a < b) ? 32'd1 : 32'd0;
            5'd6:  r = a & b;
            5'd7:  r = a | b;
            5'd8:  r = a ^ b;
            5'd9:  r = ~(a | b);
            5'd10: r = b << 16;
            5'd11: r = b << sh;
            5'd12: r = b >> sh;
            5'd13: r = $unsigned($signed(b) >>> sh);
            5'd14: r = b << a[4:0];
            5'd15: r = b >> a[4:0];
            5'd16: r = $unsigned($signed(b) >>> a[4:0]);
            default: r = '0;
        endcase
    endfunction

    task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b, input logic [4:0] sh);
        logic [31:0] er;
        logic        eo;
        @(posedge clk);
        op_sel = op; src_a = a; src_b = b; shamt_imm = sh;
        model(op, a, b, sh, er, eo);
        @(negedge clk);
        total++;
        if (result !== er) begin
            bad++;
            $display("FAIL %s result op=%0d a=%h b=%h sh=%0d actual=%h expected=%h",
                     req_of(op), op, a, b, sh, result, er);
        end
        total++;
        if (ovf_trap !== eo) begin
            bad++;
            $display("FAIL %s ovf op=%0d a=%h b=%h actual=%b expected=%b",
                     (op == 5'd0 || op == 5'd2) ? "R2" : "R3", op, a, b, ovf_trap, eo);
        end
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_0000;
            4: return 32'h0000_0001;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        // all-zero inputs give a zero result and no trap request
        run(5'd0, 32'h0, 32'h0, 5'd0);
        // R2: signed overflow in both directions, trapping forms
        run(5'd0, 32'h7FFF_FFFF, 32'h1, 5'd0);
        run(5'd2, 32'h8000_0000, 32'h1, 5'd0);
        run(5'd2, 32'h0, 32'h8000_0000, 5'd0);
        // R1: the same operands in the wrapping forms
        run(5'd1, 32'h7FFF_FFFF, 32'h1, 5'd0);
        run(5'd3, 32'h8000_0000, 32'h1, 5'd0);
        // R3: an unsigned carry out is not a trap
        run(5'd0, 32'hFFFF_FFFF, 32'h1, 5'd0);
        // R4, R5: -1 against 1 splits the signed and unsigned compares
        run(5'd4, 32'hFFFF_FFFF, 32'h1, 5'd0);
        run(5'd5, 32'hFFFF_FFFF, 32'h1, 5'd0);
        run(5'd4, 32'h5, 32'h5, 5'd0);
        // R6: the NOR example
        run(5'd9, 32'hFF00_FF00, 32'hF0F0_F0F0, 5'd0);
        // R7: upper-half placement drops the upper bits of B
        run(5'd10, 32'h0, 32'hDEAD_C0DE, 5'd0);
        // R8: counts 0 and 31, arithmetic fill on a negative value
        run(5'd13, 32'h0, 32'h8000_0000, 5'd31);
        run(5'd12, 32'h0, 32'h8000_0000, 5'd31);
        run(5'd11, 32'h0, 32'h8000_0001, 5'd0);
        // R9: A bits above bit 4 set, effective count 5
        run(5'd14, 32'hFFFF_FFE5, 32'h0000_0003, 5'd0);
        run(5'd16, 32'hABCD_0025, 32'hF000_0000, 5'd9);
        run(5'd15, 32'h0000_0020, 32'h1234_5678, 5'd7);
        // R10: unused codes
        run(5'd17, 32'h7FFF_FFFF, 32'h1, 5'd3);
        run(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31);
        for (int n = 0; n < 4000; n++) begin
            run(5'($urandom_range(0, 31)), pick(), pick(), 5'($urandom()));
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL all: watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule